// File: doc/BRIEF.md
# Event Arrival Jitter Estimator

This unit watches one repeated event, such as the arrival of successive bits, and estimates how irregular its spacing is. Each time the event strobe is high, the unit samples a free-running cycle timestamp. It forms the distance in cycles to the previous occurrence and keeps a running integer estimate of the mean spacing. From that mean it keeps a smoothed mean absolute deviation, which serves as the jitter figure. All times are in cycles of the fastest system clock. A bound of 10 µs at 1 MHz is therefore a limit of 10.

The unit sits beside a sequence controller. The controller strobes it at its observation point, reads back the jitter value and the valid flag, and counts occurrences through the saturating occurrence counter. The controller can also use the built-in comparison against a limit it supplies. A synchronous clear restarts the whole estimate. Averaging uses right shifts by a parameter `SHIFT`, which is 2 by default. Each shift rounds toward minus infinity.

Top module: `evt_jitter_unit`

## Requirements
- R1: After reset, `occ_count`, `jitter`, `jitter_valid` and `over_limit` are all 0.
- R2: The first strobe after reset or clear only stores the timestamp. `occ_count` becomes 1, while `jitter` stays 0 and `jitter_valid` stays 0.
- R3: Each strobe raises `occ_count` by 1 in the cycle after it. The count holds at 2^CNT_W-1 (255 by default) and never wraps to 0.
- R4: The interval is the current timestamp minus the previous one, taken modulo 2^TS_W. A timestamp that wraps past zero therefore gives the true short interval.
- R5: The first interval (second strobe) loads the mean directly. Every later interval updates it as mean + ((interval - mean) >>> SHIFT), using an arithmetic, flooring shift.
- R6: For each interval from the second on, the deviation is |interval - mean| against the mean held before that strobe. The second interval loads `jitter` with this deviation. Later intervals update it as jitter + ((dev - jitter) >>> SHIFT).
- R7: `jitter_valid` is 1 exactly when at least two intervals have been seen, that is from the third strobe on.
- R8: `over_limit` is 1 exactly when `jitter_valid` is 1 and `jitter` > `limit` (strictly greater).
- R9: `clear` returns every output to its reset value in the next cycle, even when a strobe arrives in the same cycle.
- R10: In a cycle without strobe or clear, `occ_count`, `jitter` and `jitter_valid` keep their values, whatever `stamp` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Synchronous restart of the estimate |
| evt_strobe | input | 1 | One occurrence of the observed event |
| stamp | input | TS_W | Free-running cycle timestamp |
| limit | input | TS_W | Jitter bound used by the comparator |
| jitter | output | TS_W | Smoothed mean absolute deviation of the interval |
| jitter_valid | output | 1 | Jitter estimate is based on at least two intervals |
| over_limit | output | 1 | Valid jitter is above `limit` |
| occ_count | output | CNT_W | Saturating occurrence count |

## Verification
The bench aims at the seeding order. A design that let the first interval touch the jitter, or that measured deviation against the freshly updated mean, would report non-zero jitter for a perfectly regular event or drift from the expected values. It sends a timestamp that wraps past zero; a design that does not take the interval modulo the timestamp width would see a huge interval and a huge deviation. It also drives the limit both equal to and one below the jitter value to catch a comparator that is not strict. It sends more strobes than the counter can hold, so a wrapping counter would drop back to zero and restart seeding. Finally it drives clear and strobe together; a design that gave the strobe priority would keep a count of 1.

// File: rtl/evt_jit_pkg.sv
package evt_jit_pkg;

   // position of the incoming strobe in the seeding sequence
   typedef enum logic [1:0] {
      PH_FIRST = 2'd0,   // no timestamp stored yet
      PH_SEED  = 2'd1,   // first interval: seeds the mean
      PH_PRIME = 2'd2,   // second interval: seeds the jitter
      PH_RUN   = 2'd3    // steady smoothing
   } seq_phase_t;

endpackage

// File: rtl/occ_stamp_tracker.sv
module occ_stamp_tracker
   import evt_jit_pkg::*;
#(
   parameter int TS_W  = 16,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             strobe,
   input  logic [TS_W-1:0]  stamp,
   output logic [CNT_W-1:0] occ,
   output logic [TS_W-1:0]  interval,
   output seq_phase_t       phase
);

   localparam logic [CNT_W-1:0] OCC_MAX = {CNT_W{1'b1}};

   logic [TS_W-1:0] last_q;

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("occ_stamp_tracker: CNT_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ    <= '0;
         last_q <= '0;
      end else if (clear) begin
         occ    <= '0;
         last_q <= '0;
      end else if (strobe) begin
         last_q <= stamp;
         if (occ != OCC_MAX) occ <= occ + 1'b1;
      end
   end

   // modular difference handles timestamp roll-over
   assign interval = stamp - last_q;

   always_comb begin
      if (occ == '0)                          phase = PH_FIRST;
      else if (occ == {{(CNT_W-1){1'b0}},1'b1}) phase = PH_SEED;
      else if (occ == {{(CNT_W-2){1'b0}},2'b10}) phase = PH_PRIME;
      else                                    phase = PH_RUN;
   end

   // R3: a non-zero count never returns to zero without clear
   a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (occ != '0 && !clear) |=> occ != '0);

endmodule

// File: rtl/shift_avg.sv
module shift_avg #(
   parameter int W  = 16,
   parameter int SH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         load,
   input  logic         upd,
   input  logic [W-1:0] sample,
   output logic [W-1:0] avg
);

   logic [W-1:0] nxt;

   generate
      if (SH < 0 || SH >= W) begin : g_bad_shift
         $error("shift_avg: SH must lie in 0..W-1");
      end
      if (SH == 0) begin : g_track
         // no smoothing: follow the latest sample
         assign nxt = sample;
      end else begin : g_smooth
         logic signed [W+1:0] diff_w, step_w, sum_w;
         logic [1:0]          unused_hi;
         always_comb begin
            diff_w = $signed({2'b00, sample}) - $signed({2'b00, avg});
            step_w = diff_w >>> SH;
            sum_w  = $signed({2'b00, avg}) + step_w;
         end
         assign nxt       = sum_w[W-1:0];
         assign unused_hi = sum_w[W+1:W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     avg <= '0;
      else if (clear) avg <= '0;
      else if (load)  avg <= sample;
      else if (upd)   avg <= nxt;
   end

   // R5/R6: a smoothing step moves toward the sample and never past it
   a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !load && !clear && sample >= avg) |=>
         (avg >= $past(avg) && avg <= $past(sample)));
   a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !load && !clear && sample <= avg) |=>
         (avg <= $past(avg) && avg >= $past(sample)));

endmodule

// File: rtl/evt_jitter_unit.sv
module evt_jitter_unit
   import evt_jit_pkg::*;
#(
   parameter int TS_W  = 16,
   parameter int CNT_W = 8,
   parameter int SHIFT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             evt_strobe,
   input  logic [TS_W-1:0]  stamp,
   input  logic [TS_W-1:0]  limit,
   output logic [TS_W-1:0]  jitter,
   output logic             jitter_valid,
   output logic             over_limit,
   output logic [CNT_W-1:0] occ_count
);

   logic [TS_W-1:0] interval, mean, dev;
   seq_phase_t      phase;
   logic            take;
   logic            mean_load, mean_upd, jit_load, jit_upd;
   logic signed [TS_W:0] gap;
   logic signed [TS_W:0] mag;
   logic            unused_sign;

   occ_stamp_tracker #(.TS_W(TS_W), .CNT_W(CNT_W)) u_track (
      .clk(clk), .rst_n(rst_n), .clear(clear), .strobe(evt_strobe),
      .stamp(stamp), .occ(occ_count), .interval(interval), .phase(phase)
   );

   assign take      = evt_strobe && !clear;
   assign mean_load = take && (phase == PH_SEED);
   assign mean_upd  = take && (phase == PH_PRIME || phase == PH_RUN);
   assign jit_load  = take && (phase == PH_PRIME);
   assign jit_upd   = take && (phase == PH_RUN);

   // deviation against the mean held before this strobe
   always_comb begin
      gap = $signed({1'b0, interval}) - $signed({1'b0, mean});
      mag = (gap < 0) ? -gap : gap;
   end
   assign dev         = mag[TS_W-1:0];
   assign unused_sign = mag[TS_W];

   shift_avg #(.W(TS_W), .SH(SHIFT)) u_mean (
      .clk(clk), .rst_n(rst_n), .clear(clear), .load(mean_load),
      .upd(mean_upd), .sample(interval), .avg(mean)
   );

   shift_avg #(.W(TS_W), .SH(SHIFT)) u_jit (
      .clk(clk), .rst_n(rst_n), .clear(clear), .load(jit_load),
      .upd(jit_upd), .sample(dev), .avg(jitter)
   );

   assign jitter_valid = (phase == PH_RUN);
   assign over_limit   = jitter_valid && (jitter > limit);

   // R9: clear wins over a simultaneous strobe
   a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (occ_count == '0 && !jitter_valid && jitter == '0));

   // R10: nothing moves without a strobe
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_strobe && !clear) |=>
         ($stable(occ_count) && $stable(jitter) && $stable(jitter_valid)));

endmodule

// File: tb/test_evt_jitter_unit.sv
module test_evt_jitter_unit;

   localparam int TS_W  = 16;
   localparam int CNT_W = 8;
   localparam int SH    = 2;
   localparam int MASK  = (1 << TS_W) - 1;
   localparam int OMAX  = (1 << CNT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clear = 1'b0;
   logic evt_strobe = 1'b0;
   logic [TS_W-1:0] stamp = '0;
   logic [TS_W-1:0] limit = 16'd1000;
   logic [TS_W-1:0] jitter;
   logic jitter_valid, over_limit;
   logic [CNT_W-1:0] occ_count;

   int total = 0;
   int bad   = 0;
   int m_occ, m_last, m_mean, m_jit;

   always #5 clk = ~clk;

   evt_jitter_unit #(.TS_W(TS_W), .CNT_W(CNT_W), .SHIFT(SH)) i_evt_jitter_unit (
      .clk(clk), .rst_n(rst_n), .clear(clear), .evt_strobe(evt_strobe),
      .stamp(stamp), .limit(limit), .jitter(jitter),
      .jitter_valid(jitter_valid), .over_limit(over_limit),
      .occ_count(occ_count)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_occ = 0; m_last = 0; m_mean = 0; m_jit = 0;
   endtask

   task automatic compare_all(input string req);
      int v;
      v = (m_occ >= 3) ? 1 : 0;
      chk(req, "occ_count", int'(occ_count), m_occ);
      chk(req, "jitter", int'(jitter), m_jit);
      chk(req, "jitter_valid", int'(jitter_valid), v);
      chk(req, "over_limit", int'(over_limit), (v == 1 && m_jit > int'(limit)) ? 1 : 0);
   endtask

   // one strobe; model follows R2..R7
   task automatic pulse(input int s);
      int iv, dev;
      @(negedge clk);
      evt_strobe = 1'b1;
      stamp = s[TS_W-1:0];
      if (m_occ >= 1) begin
         iv = (s - m_last) & MASK;
         if (m_occ == 1) m_mean = iv;
         else begin
            dev = (iv > m_mean) ? iv - m_mean : m_mean - iv;
            if (m_occ == 2) m_jit = dev;
            else m_jit = m_jit + ((dev - m_jit) >>> SH);
            m_mean = m_mean + ((iv - m_mean) >>> SH);
         end
      end
      m_last = s & MASK;
      if (m_occ < OMAX) m_occ++;
      @(negedge clk);
      evt_strobe = 1'b0;
   endtask

   task automatic do_clear();
      @(negedge clk);
      clear = 1'b1;
      @(negedge clk);
      clear = 1'b0;
      model_reset();
   endtask

   task automatic t_reset();
      compare_all("R1");
   endtask

   task automatic t_first();
      pulse(100);
      compare_all("R2");
   endtask

   task automatic t_steady();
      pulse(110);
      compare_all("R7");
      chk("R6", "jitter after first interval", int'(jitter), 0);
      pulse(120);
      compare_all("R7");
      chk("R6", "regular spacing", int'(jitter), 0);
   endtask

   task automatic t_vary();
      pulse(134); compare_all("R5");
      pulse(140); compare_all("R6");
      pulse(160); compare_all("R6");
      pulse(161); compare_all("R5");
   endtask

   task automatic t_hold();
      int j0, o0;
      j0 = int'(jitter); o0 = int'(occ_count);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         stamp = stamp + 16'd333;
      end
      @(negedge clk);
      chk("R10", "jitter held", int'(jitter), j0);
      chk("R10", "occ held", int'(occ_count), o0);
      compare_all("R10");
   endtask

   task automatic t_limit();
      limit = m_jit[TS_W-1:0];
      @(negedge clk);
      chk("R8", "equal limit", int'(over_limit), 0);
      limit = m_jit[TS_W-1:0] - 16'd1;
      @(negedge clk);
      chk("R8", "limit below", int'(over_limit), (m_jit > 0) ? 1 : 0);
      limit = 16'd1000;
      @(negedge clk);
      chk("R8", "large limit", int'(over_limit), 0);
   endtask

   task automatic t_clear_prio();
      @(negedge clk);
      clear = 1'b1;
      evt_strobe = 1'b1;
      stamp = 16'd500;
      @(negedge clk);
      clear = 1'b0;
      evt_strobe = 1'b0;
      model_reset();
      compare_all("R9");
      pulse(600);
      compare_all("R2");
   endtask

   task automatic t_wrap();
      do_clear();
      pulse(65530);
      pulse(4);
      pulse(14);
      compare_all("R4");
      chk("R4", "wrapped interval equals next", int'(jitter), 0);
      pulse(25);
      compare_all("R4");
   endtask

   task automatic t_sat();
      do_clear();
      for (int i = 0; i < OMAX + 5; i++) pulse(i * 7 + (i % 3));
      chk("R3", "saturated count", int'(occ_count), OMAX);
      compare_all("R3");
      pulse((OMAX + 5) * 7 + 9);
      compare_all("R3");
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_first();
      t_steady();
      t_vary();
      t_hold();
      t_limit();
      t_clear_prio();
      t_wrap();
      t_sat();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1000000;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule